// File: doc/BRIEF.md
# Burst Address Generator

This block sits in front of one port of a synchronous memory and produces the address that the array decodes on every cycle. It holds an internal counter register. On each rising clock edge the register is cleared to zero, loaded from the external address bus, advanced by one, or left unchanged. Three active-low control pins make that choice: a counter clear, an address strobe and a count enable.

The address sent to the memory is set by the strobe alone. While the strobe is low, the external address goes straight through to the array with no register in the path. While the strobe is high, the array sees the counter. A host starts a burst by strobing in a start address. It then holds the count enable low, so that each later cycle touches the next location. The counter wraps from the highest address back to zero. A clear takes effect at the edge it is sampled on, so the next cycle can access address zero with no idle cycle in between. Chip enables and data movement are outside this block and have no effect on the counter.

Top module: `burst_addr_gen`

## Requirements
- R1: While the clear pin `cntClrN` is low at a rising edge, the counter becomes zero, whatever the levels of `adsN` and `cntEnN`.
- R2: While `adsN` is low and `cntClrN` is high at a rising edge, the counter takes the value of `extAddr`.
- R3: While `cntEnN` is low and both `adsN` and `cntClrN` are high at a rising edge, the counter rises by one.
- R4: While `adsN`, `cntEnN` and `cntClrN` are all high at a rising edge, the counter keeps its value, and changes on `extAddr` have no effect on it.
- R5: Advancing from the all-ones address (2^ADDR_W - 1) gives zero, and the following advance gives one.
- R6: `intAddr` equals `extAddr` in the same cycle while `adsN` is low, and equals the counter while `adsN` is high.
- R7: A high level on the synchronous system reset `rst` at a rising edge sets the counter to zero.
- R8: A clear costs no cycle. In the cycle after a clear, with `adsN` high, `intAddr` is zero, and a count enable held low in that cycle gives one on the edge after it.
- R9: A low `cntEnN` has no effect while `adsN` is low: the counter takes `extAddr` exactly, not `extAddr` + 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous system reset, active high |
| adsN | input | 1 | Address strobe, active low: loads the counter and passes the external address through |
| cntEnN | input | 1 | Count enable, active low |
| cntClrN | input | 1 | Counter clear, active low, highest priority |
| extAddr | input | ADDR_W | External address |
| intAddr | output | ADDR_W | Address sent to the memory array |

## Verification
A wrong counter value does not show while the strobe is low, because the pass-through hides it. It shows on `intAddr` in the first cycle the strobe is high. Every check of counter state therefore releases the strobe and samples `intAddr` one cycle after the edge under test. A wrong priority between clear, load and count, or a wrong wrap, makes that address differ from the expected one after a single edge. A fault that only affects the carry, such as a wrap at the wrong value, shows only when a burst crosses the top of the address space.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;
  // One-hot (or empty) command from control to datapath for the next edge.
  typedef struct packed {
    logic clear;    // force counter to zero
    logic load;     // capture external address
    logic advance;  // increment with wrap
  } cnt_cmd_t;
endpackage

// File: rtl/burst_addr_ctrl.sv
module burst_addr_ctrl
  import burst_addr_pkg::*;
(
  input  logic     adsN,
  input  logic     cntEnN,
  input  logic     cntClrN,
  output cnt_cmd_t cmd,
  output logic     selExt
);
  // Priority: clear > load > advance > hold.
  always_comb begin
    cmd = '0;
    if (!cntClrN)     cmd.clear   = 1'b1;
    else if (!adsN)   cmd.load    = 1'b1;
    else if (!cntEnN) cmd.advance = 1'b1;
  end

  // The strobe alone steers the output, independent of the clear.
  assign selExt = !adsN;
endmodule

// File: rtl/burst_addr_dp.sv
module burst_addr_dp
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  cnt_cmd_t          cmd,
  input  logic              selExt,
  input  logic [ADDR_W-1:0] extAddr,
  output logic [ADDR_W-1:0] cntQ,
  output logic [ADDR_W-1:0] intAddr
);
  localparam logic [ADDR_W-1:0] TopAddr = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] OneAddr = {{(ADDR_W-1){1'b0}}, 1'b1};

  logic [ADDR_W-1:0] cntNext;
  logic [ADDR_W-1:0] cntInc;

  assign cntInc = (cntQ == TopAddr) ? '0 : cntQ + OneAddr;

  always_comb begin
    cntNext = cntQ;
    if (cmd.clear)        cntNext = '0;
    else if (cmd.load)    cntNext = extAddr;
    else if (cmd.advance) cntNext = cntInc;
  end

  always_ff @(posedge clk) begin
    if (rst) cntQ <= '0;
    else     cntQ <= cntNext;
  end

  assign intAddr = selExt ? extAddr : cntQ;
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adsN,
  input  logic              cntEnN,
  input  logic              cntClrN,
  input  logic [ADDR_W-1:0] extAddr,
  output logic [ADDR_W-1:0] intAddr
);
  localparam logic [ADDR_W-1:0] OneAddr = {{(ADDR_W-1){1'b0}}, 1'b1};

  cnt_cmd_t          cmd;
  logic              selExt;
  logic [ADDR_W-1:0] counterQ;

  burst_addr_ctrl u_ctrl (
    .adsN   (adsN),
    .cntEnN (cntEnN),
    .cntClrN(cntClrN),
    .cmd    (cmd),
    .selExt (selExt)
  );

  burst_addr_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk    (clk),
    .rst    (rst),
    .cmd    (cmd),
    .selExt (selExt),
    .extAddr(extAddr),
    .cntQ   (counterQ),
    .intAddr(intAddr)
  );

  // R1: clear wins over strobe and count enable
  p_clear_wins_r1: assert property (@(posedge clk) disable iff (rst)
    !cntClrN |=> counterQ == '0);

  // R1: at most one command reaches the datapath
  p_cmd_exclusive_r1: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cmd.clear, cmd.load, cmd.advance}));

  // R2, R9: load captures the external address exactly
  p_load_exact_r2: assert property (@(posedge clk) disable iff (rst)
    (cntClrN && !adsN) |=> counterQ == $past(extAddr));

  // R3, R5: advance is +1 modulo the address space
  p_advance_r3: assert property (@(posedge clk) disable iff (rst)
    (cntClrN && adsN && !cntEnN) |=> counterQ == $past(counterQ) + OneAddr);

  // R4: hold keeps the counter
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (cntClrN && adsN && cntEnN) |=> $stable(counterQ));

  // R6: strobe high exposes the counter at the port
  p_expose_r6: assert property (@(posedge clk) disable iff (rst)
    adsN |-> intAddr == counterQ);
endmodule

// File: tb/burst_addr_gen_test.sv
`timescale 1ns/1ps
module burst_addr_gen_test;
  localparam int W = 13;
  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic adsN = 1'b1, cntEnN = 1'b1, cntClrN = 1'b1;
  logic [W-1:0] extAddr = '0;
  logic [W-1:0] intAddr;

  int nChecks = 0;
  int nFails  = 0;

  always #2 clk = ~clk;  // 250 MHz

  burst_addr_gen #(.ADDR_W(W)) uut (
    .clk(clk), .rst(rst), .adsN(adsN), .cntEnN(cntEnN),
    .cntClrN(cntClrN), .extAddr(extAddr), .intAddr(intAddr)
  );

  task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: intAddr=%h expected=%h at %0t", req, got, exp, $time);
    end
  endtask

  // advance one edge; inputs change 1 ns after the edge
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic setCtl(input logic a, input logic e, input logic c, input logic [W-1:0] x);
    adsN = a; cntEnN = e; cntClrN = c; extAddr = x;
  endtask

  task automatic t_reset();
    setCtl(1, 1, 1, 13'h0F0F);
    rst = 1'b1; tick(); tick();
    rst = 1'b0; #1;
    check("R7", intAddr, '0);
  endtask

  task automatic t_load();
    setCtl(0, 1, 1, 13'h0123); #1;
    check("R6", intAddr, 13'h0123);
    tick();
    setCtl(1, 1, 1, 13'h00AA); #1;
    check("R2", intAddr, 13'h0123);
  endtask

  task automatic t_increment();
    for (int i = 1; i <= 4; i++) begin
      setCtl(1, 0, 1, 13'h1000 + 13'(i));
      tick();
      check("R3", intAddr, 13'h0123 + 13'(i));
    end
  endtask

  task automatic t_hold();
    for (int i = 0; i < 3; i++) begin
      setCtl(1, 1, 1, 13'h1ABC ^ 13'(i));
      tick();
      check("R4", intAddr, 13'h0127);
    end
  endtask

  task automatic t_load_beats_count();
    setCtl(0, 0, 1, 13'h0500); tick();
    setCtl(1, 1, 1, 13'h0000); #1;
    check("R9", intAddr, 13'h0500);
  endtask

  task automatic t_wrap();
    setCtl(0, 1, 1, TOP - 13'd1); tick();
    setCtl(1, 0, 1, 13'h0000); #1;
    check("R6", intAddr, TOP - 13'd1);
    tick(); check("R5", intAddr, TOP);
    tick(); check("R5", intAddr, 13'h0000);
    tick(); check("R5", intAddr, 13'h0001);
  endtask

  task automatic t_clear_with_others();
    setCtl(0, 1, 1, 13'h0777); tick();
    setCtl(0, 0, 0, 13'h0333); #1;
    check("R6", intAddr, 13'h0333);  // strobe still passes through
    tick();
    setCtl(1, 0, 1, 13'h0444); #1;
    check("R1", intAddr, 13'h0000);  // cleared despite strobe and enable
    check("R8", intAddr, 13'h0000);
    tick();
    check("R8", intAddr, 13'h0001);
    setCtl(1, 0, 0, 13'h0000); tick();
    setCtl(1, 1, 1, 13'h0000); #1;
    check("R1", intAddr, 13'h0000);  // clear beats count enable
  endtask

  task automatic t_sys_reset();
    setCtl(0, 1, 1, 13'h0ABC); tick();
    setCtl(1, 1, 1, 13'h0000);
    rst = 1'b1; tick(); rst = 1'b0; #1;
    check("R7", intAddr, 13'h0000);
  endtask

  initial begin
    #3;
    t_reset();
    t_load();
    t_increment();
    t_hold();
    t_load_beats_count();
    t_wrap();
    t_clear_with_others();
    t_sys_reset();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #(4 * 200000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule